// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with True LRU Replacement

The block is a read-only cache of 256 sets, four ways per set, and one 32-bit word per way. A requester presents a byte address on the lookup port. The cache splits the address into a tag, a set index and a byte offset, and compares the tags of all four ways of the indexed set at the same time. On a hit, a 4-to-1 way select returns the stored word one cycle after the lookup is accepted.

On a miss, the cache stalls the lookup port. It fetches the word-aligned address over a request/acknowledge memory port and installs the returned word in the chosen way. An invalid way is always chosen first, the lowest-numbered one. When all four ways are valid, the least recently used way is chosen. The fetched word is also returned as the response. A true LRU order is kept for every set as a 2-bit age per way, and it is updated on every hit and every fill.

The controller has two states. `ST_IDLE` accepts lookups. Its transitions are `T_HIT`, which stays in `ST_IDLE` and responds, and `T_MISS`, which moves to `ST_FILL` and captures the address and victim way. `ST_FILL` holds the memory request. Its transition `T_WAIT` stays in `ST_FILL` while no acknowledge has arrived. Its transition `T_FILLED` installs the word, responds and returns to `ST_IDLE`.

Top module: `assoc_lru_cache`

## Requirements
- R1: The set index is address bits 9:2 and the tag is bits 31:10. Bits 1:0 are ignored, so two addresses that differ only in bits 1:0 hit the same word. The memory request address has bits 1:0 equal to zero.
- R2: After reset every way of every set is invalid and `lk_ready` is 1. The first lookup to any set therefore misses.
- R3: A lookup accepted in a cycle where `lk_valid` and `lk_ready` are both 1 and a valid way's tag matches gives, at the next clock edge, `rsp_valid`=1, `rsp_hit`=1 and `rsp_data` equal to that way's word. No memory request is made.
- R4: On a miss, `mem_req` rises at the edge that accepts the lookup. It then holds with a stable `mem_addr` until the cycle that has `mem_ack`=1. During this time `lk_ready` is 0 and `rsp_valid` is 0.
- R5: At the edge where `mem_ack` is 1, the cache responds with `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equal to `mem_rdata`, and `lk_ready` returns to 1. The word is installed, so a repeat lookup of the same word hits.
- R6: A miss fills the lowest-numbered invalid way of the set when one exists. Four different tags in one set all stay resident.
- R7: A miss in a set whose four ways are all valid evicts the least recently used way. Later lookups to the evicted tag miss, and lookups to the other three tags hit.
- R8: Each access (hit or fill) gives the accessed way age 0. Every way whose age was lower than the accessed way's age ages by one. The victim of a full set is the way with age 3.
- R9: Two tags that map to the same set and are looked up alternately both stay resident and hit after their first misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | 32 | Lookup byte address |
| lk_ready | output | 1 | Cache can accept a lookup (low during a fill) |
| rsp_valid | output | 1 | Response valid, one cycle pulse |
| rsp_hit | output | 1 | Response came from a hit (1) or a fill (0) |
| rsp_data | output | 32 | Response word |
| mem_req | output | 1 | Fill request to memory, held until acknowledged |
| mem_addr | output | 32 | Word-aligned fill address |
| mem_ack | input | 1 | Memory returns the fill word this cycle |
| mem_rdata | input | 32 | Fill word, valid with `mem_ack` |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and only as a single-cycle pulse for each request. Under that assumption the fill state always ends cleanly, and the request-hold and response properties are meaningful. The bench's memory responder acknowledges only after it sees `mem_req`, waits zero to three cycles, pulses `mem_ack` once, and then releases it. Lookups are driven only when `lk_ready` is high, so no lookup overlaps an outstanding fill.

// File: rtl/cache_pkg.sv
package cache_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int SETS   = 256;
    parameter int WAYS   = 4;
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/cache_way_store.sv
module cache_way_store
    import cache_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  idx_t                   rd_idx,
    output logic [WAYS-1:0]        rd_valid,
    output tag_t [WAYS-1:0]        rd_tag,
    output word_t [WAYS-1:0]       rd_data,
    input  logic                   wr_en,
    input  idx_t                   wr_idx,
    input  way_t                   wr_way,
    input  tag_t                   wr_tag,
    input  word_t                  wr_data
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0] valid_q;
        tag_t            tag_q  [SETS];
        word_t           data_q [SETS];
        logic            sel;

        assign sel = wr_en && (wr_way == way_t'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
            end else if (sel) begin
                valid_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_idx]  <= wr_tag;
                data_q[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = valid_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
        assign rd_data[w]  = data_q[rd_idx];
    end
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match
    import cache_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  way_valid,
    input  tag_t [WAYS-1:0]  way_tag,
    input  word_t [WAYS-1:0] way_data,
    input  tag_t             look_tag,
    output logic             hit,
    output way_t             hit_way,
    output word_t            hit_data
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way  = way_t'(w);
                hit_data = way_data[w];
            end
        end
    end

    // R3: a word is never installed twice in one set, so at most one way matches
    p_match_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cache_lru_ages.sv
module cache_lru_ages
    import cache_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  idx_t            rd_idx,
    input  logic [WAYS-1:0] rd_valid,
    output way_t            victim,
    input  logic            upd_en,
    input  idx_t            upd_idx,
    input  way_t            upd_way
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;
    logic [WAYS-1:0][AGE_W-1:0]           cur_age;
    logic [WAYS-1:0][AGE_W-1:0]           upd_age;

    assign cur_age = age_q[rd_idx];
    assign upd_age = age_q[upd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_t'(w) == upd_way) begin
                    age_q[upd_idx][w] <= '0;
                end else if (upd_age[w] < upd_age[upd_way]) begin
                    age_q[upd_idx][w] <= upd_age[w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim = '0;
        if (!(&rd_valid)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!rd_valid[w]) victim = way_t'(w);
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (cur_age[w] == OLDEST) victim = way_t'(w);
            end
        end
    end

    // R8: the way just accessed is the youngest afterwards
    p_age_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (age_q[$past(upd_idx)][$past(upd_way)] == '0));

    // R6: with a free way present, the victim is never a valid way
    p_victim_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&rd_valid)) |-> !rd_valid[victim]);

    // R7: in a full set, the victim carries the oldest age
    p_victim_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&rd_valid) |-> (cur_age[victim] == OLDEST));
endmodule

// File: rtl/assoc_lru_cache.sv
module assoc_lru_cache
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    ctrl_state_e state_q, state_d;

    idx_t  cap_idx_q;
    tag_t  cap_tag_q;
    way_t  victim_q;

    idx_t  lk_idx;
    tag_t  lk_tag;
    idx_t  rd_idx;
    logic  accept;

    logic [WAYS-1:0] rd_valid;
    tag_t  [WAYS-1:0] rd_tag;
    word_t [WAYS-1:0] rd_data;

    logic  look_hit;
    way_t  hit_way;
    word_t hit_data;
    way_t  victim;

    logic  fill_done;
    logic  upd_en;
    idx_t  upd_idx;
    way_t  upd_way;

    assign lk_idx    = lk_addr[OFF_W +: IDX_W];
    assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_ready  = (state_q == ST_IDLE);
    assign accept    = lk_valid && lk_ready;
    assign rd_idx    = (state_q == ST_IDLE) ? lk_idx : cap_idx_q;
    assign fill_done = (state_q == ST_FILL) && mem_ack;
    assign mem_req   = (state_q == ST_FILL);
    assign mem_addr  = {cap_tag_q, cap_idx_q, {OFF_W{1'b0}}};

    cache_way_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (fill_done),
        .wr_idx   (cap_idx_q),
        .wr_way   (victim_q),
        .wr_tag   (cap_tag_q),
        .wr_data  (mem_rdata)
    );

    cache_tag_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .way_valid (rd_valid),
        .way_tag   (rd_tag),
        .way_data  (rd_data),
        .look_tag  (lk_tag),
        .hit       (look_hit),
        .hit_way   (hit_way),
        .hit_data  (hit_data)
    );

    always_comb begin
        upd_en  = 1'b0;
        upd_idx = lk_idx;
        upd_way = hit_way;
        if (fill_done) begin
            upd_en  = 1'b1;
            upd_idx = cap_idx_q;
            upd_way = victim_q;
        end else if (accept && look_hit) begin
            upd_en  = 1'b1;
        end
    end

    cache_lru_ages u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .victim   (victim),
        .upd_en   (upd_en),
        .upd_idx  (upd_idx),
        .upd_way  (upd_way)
    );

    // next-state: T_HIT, T_MISS, T_WAIT, T_FILLED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !look_hit) state_d = ST_FILL;
            ST_FILL: if (mem_ack)             state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
            cap_idx_q <= '0;
            cap_tag_q <= '0;
            victim_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rsp_valid <= accept && look_hit;
                    rsp_hit   <= accept && look_hit;
                    if (accept && look_hit) rsp_data <= hit_data;
                    if (accept && !look_hit) begin
                        cap_idx_q <= lk_idx;
                        cap_tag_q <= lk_tag;
                        victim_q  <= victim;
                    end
                end
                ST_FILL: begin
                    rsp_valid <= mem_ack;
                    rsp_hit   <= 1'b0;
                    if (mem_ack) rsp_data <= mem_rdata;
                end
                default: begin
                    rsp_valid <= 1'b0;
                    rsp_hit   <= 1'b0;
                end
            endcase
        end
    end

    // R3: an accepted hit responds at the next edge as a hit
    p_hit_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && look_hit) |=> (rsp_valid && rsp_hit));

    // R4: the fill request and its address hold until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: no response is produced while a fill is outstanding
    p_fill_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid);

    // R5: an acknowledged fill responds as a miss and reopens the port
    p_fill_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !rsp_hit && lk_ready));
endmodule

// File: tb/assoc_lru_cache_tb_top.sv
module assoc_lru_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    assoc_lru_cache dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int dly  = 0;
    bit done = 1'b0;

    // behavioural model
    bit          m_valid [256][4];
    int unsigned m_tag   [256][4];
    logic [31:0] m_data  [256][4];
    int          m_age   [256][4];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic touch(input int s, input int w);
        int a = m_age[s][w];
        for (int v = 0; v < 4; v++) begin
            if (v == w) m_age[s][v] = 0;
            else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
        end
    endtask

    function automatic int pick_victim(input int s);
        for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) return w;
        return 0;
    endfunction

    task automatic lookup(input logic [31:0] a, input string rq);
        int s = int'(a[9:2]);
        int unsigned t = a[31:10];
        int hw = -1;
        logic [31:0] exp_w;
        for (int w = 0; w < 4; w++) if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        if (hw >= 0) begin
            check(rsp_valid === 1'b1 && rsp_hit === 1'b1 && mem_req === 1'b0,
                  {rq, " R3 hit flags"}, {29'd0, rsp_valid, rsp_hit, mem_req}, 32'h6);
            check(rsp_data === m_data[s][hw], {rq, " R3 hit data"}, rsp_data, m_data[s][hw]);
            touch(s, hw);
        end else begin
            exp_w = {a[31:2], 2'b00};
            check(mem_req === 1'b1 && lk_ready === 1'b0 && rsp_valid === 1'b0,
                  {rq, " R4 request"}, {29'd0, mem_req, lk_ready, rsp_valid}, 32'h4);
            check(mem_addr === exp_w, {rq, " R1 fill address"}, mem_addr, exp_w);
            dly = (dly + 1) % 4;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                check(mem_req === 1'b1 && rsp_valid === 1'b0 && mem_addr === exp_w,
                      {rq, " R4 hold"}, mem_addr, exp_w);
            end
            mem_ack   = 1'b1;
            mem_rdata = mem_word(exp_w);
            @(negedge clk);
            mem_ack = 1'b0;
            check(rsp_valid === 1'b1 && rsp_hit === 1'b0 && lk_ready === 1'b1 && mem_req === 1'b0,
                  {rq, " R5 fill flags"}, {28'd0, rsp_valid, rsp_hit, lk_ready, mem_req}, 32'hA);
            check(rsp_data === mem_word(exp_w), {rq, " R5 fill data"}, rsp_data, mem_word(exp_w));
            hw = pick_victim(s);
            m_valid[s][hw] = 1'b1;
            m_tag[s][hw]   = t;
            m_data[s][hw]  = mem_word(exp_w);
            touch(s, hw);
        end
    endtask

    // expect a given outcome, independent of the model, for directed cases
    task automatic expect_hit(input logic [31:0] a, input bit exp_hit, input string rq);
        int s = int'(a[9:2]);
        int unsigned t = a[31:10];
        bit mh = 1'b0;
        for (int w = 0; w < 4; w++) if (m_valid[s][w] && m_tag[s][w] == t) mh = 1'b1;
        check(mh == exp_hit, {rq, " outcome"}, {31'd0, mh}, {31'd0, exp_hit});
        lookup(a, rq);
    endtask

    function automatic logic [31:0] mk(input int unsigned tag, input int idx, input int off);
        return {tag[21:0], idx[7:0], off[1:0]};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0;
                m_tag[s][w]   = 0;
                m_data[s][w]  = '0;
                m_age[s][w]   = w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(lk_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
              "R2 reset state", {29'd0, lk_ready, rsp_valid, mem_req}, 32'h4);

        // R2: first access misses; R1: other byte offset hits same word
        expect_hit(mk(22'h00ABC, 8'h8D, 0), 1'b0, "R2");
        expect_hit(mk(22'h00ABC, 8'h8D, 3), 1'b1, "R1");
        expect_hit(mk(22'h00ABC, 8'h8E, 1), 1'b0, "R1 next set");

        // R9: alternating conflicting tags both stay resident
        expect_hit(mk(22'h00ABD, 8'h8D, 0), 1'b0, "R9");
        for (int i = 0; i < 3; i++) begin
            expect_hit(mk(22'h00ABC, 8'h8D, 2), 1'b1, "R9");
            expect_hit(mk(22'h00ABD, 8'h8D, 1), 1'b1, "R9");
        end

        // R6: four tags fill the four free ways of one set
        for (int t = 1; t <= 4; t++) expect_hit(mk(t, 8'h20, 0), 1'b0, "R6");
        for (int t = 1; t <= 4; t++) expect_hit(mk(t, 8'h20, 0), 1'b1, "R6");

        // R7/R8: make tag 1 the oldest, then a new tag evicts it
        expect_hit(mk(2, 8'h20, 0), 1'b1, "R8");
        expect_hit(mk(3, 8'h20, 0), 1'b1, "R8");
        expect_hit(mk(4, 8'h20, 0), 1'b1, "R8");
        expect_hit(mk(5, 8'h20, 0), 1'b0, "R7");
        expect_hit(mk(2, 8'h20, 0), 1'b1, "R7");
        expect_hit(mk(1, 8'h20, 0), 1'b0, "R7");
        expect_hit(mk(3, 8'h20, 0), 1'b0, "R8 next oldest");
        expect_hit(mk(5, 8'h20, 0), 1'b1, "R8");

        // R8: mixed traffic against the model
        rs = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            rs = rs ^ (rs << 13);
            rs = rs ^ (rs >> 17);
            rs = rs ^ (rs << 5);
            lookup(mk(rs[2:0] % 6, 8'h40 + int'(rs[9:8]), int'(rs[5:4])), "R8 random");
        end

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule